// File: doc/BRIEF.md
# Edge-Triggered External Interrupt and Event Controller

This block watches twenty external input lines and turns selected transitions on them into interrupt requests and event pulses. Lines 0 to 15 are multiplexed: each one takes pin n of a port chosen by a 4-bit selector field. Lines 16 to 19 each come from a dedicated input. Every raw input is resynchronised to the block clock. Each line then has an edge detector that can be armed for rising edges, falling edges or both. A line can also be fired from software.

A detected trigger sets a sticky per-line pending flag. The flag stays set until software clears it by writing 1 to it. A line's interrupt request is its pending flag gated by that line's interrupt mask. Apart from this, every trigger produces a one-cycle event pulse for other hardware, gated by a separate event mask. The event path does not use the pending flag. All configuration and status goes through a small register interface with a single-cycle write strobe and a combinational read.

Top module: `exti_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `evt_o` are all 0.
- R2: A 0-to-1 change on a line whose rise-enable bit (address 0) is set sets that line's pending bit (address 5). The new value is visible after the third rising clock edge that follows the input change.
- R3: A 1-to-0 change on a line whose fall-enable bit (address 1) is set sets its pending bit with the same latency. With both enable bits set, either direction sets it.
- R4: A transition whose direction is not enabled for that line leaves its pending bit at 0.
- R5: `irq_o[n]` equals pending bit n ANDed with interrupt-mask bit n (address 2).
- R6: Each trigger produces a pulse on `evt_o[n]` that lasts exactly one cycle, if event-mask bit n (address 3) is set. The pulse arrives in the same cycle that the pending bit becomes visible. A trigger produces the pulse even when the pending bit is already set, and a cleared event-mask bit blocks it.
- R7: A write to the software-trigger register (address 4) stores the written bits. Each bit that goes from 0 to 1 sets that line's pending bit and produces an event pulse, both after the write's clock edge.
- R8: Writing 1 to a pending bit clears it and also clears the line's software-trigger bit. Writing 0 to a pending bit has no effect. If a trigger for the line occurs in the same cycle as the clear, the pending bit stays set.
- R9: Selector register k (address 8+k, bits 15:0) holds the fields for lines 4k to 4k+3. Line 4k+j uses bits [4j+3:4j]. Field value v connects line n to `port_pins_i[16*v+n]` for v < 5. Any larger value holds the line at 0.
- R10: Changing a line's selector field does not, by itself, set the pending bit or produce an event. Edges on the newly selected pin are detected afterwards.
- R11: Line 16+m is driven by `direct_i[m]`, and no selector affects it.
- R12: Register bits above bit 19, bits above bit 15 of the selector registers, and unmapped addresses all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pins_i | input | 80 | Asynchronous port pins, 16 per port, port p at bits [16p+15:16p] |
| direct_i | input | 4 | Asynchronous inputs for lines 16 to 19 |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 20 | Masked pending interrupt requests |
| evt_o | output | 20 | One-cycle masked event pulses |

## Verification
The bench builds the block with its default parameters: twenty lines, sixteen multiplexed lines and five ports. This makes every selector value reachable, including the out-of-range values 5 to 15 that must hold a line at zero, as well as the four direct lines. A selector test switches a line onto a pin that already sits at the opposite level, which exercises the reload of the previous sample. Randomised rounds combine random enables, masks and selectors with single input transitions. Directed cases time a pending clear so that it lands in the same cycle as a new trigger.

// File: rtl/exti_pkg.sv
// Package exti_pkg: register addresses and shared constants for the
// external interrupt and event controller. Assumes a 4-bit register address.
package exti_pkg;
    localparam int ADDR_RISE     = 0;   // rising-edge enables
    localparam int ADDR_FALL     = 1;   // falling-edge enables
    localparam int ADDR_IMASK    = 2;   // interrupt mask
    localparam int ADDR_EMASK    = 3;   // event mask
    localparam int ADDR_SWTRIG   = 4;   // software trigger
    localparam int ADDR_PEND     = 5;   // pending flags, write 1 to clear
    localparam int ADDR_SEL_BASE = 8;   // first source-selector register
    localparam int SEL_REG_BITS  = 16;  // used bits per selector register
endpackage

// File: rtl/exti_sync.sv
// Module exti_sync: two-flop resynchroniser for a bus of independent
// asynchronous bits. Assumes each bit is sampled on its own, with no
// relationship between bits.
module exti_sync #(
    parameter int WIDTH = 84
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture the raw inputs, then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/exti_line_mux.sv
// Module exti_line_mux: picks, for each multiplexed line n, pin n of the
// port named by that line's selector field. A field value past the last
// port gives a constant 0. Assumes synchronised pins, port p at
// bits [p*NUM_MUXED +: NUM_MUXED].
module exti_line_mux #(
    parameter int NUM_MUXED = 16,
    parameter int NUM_PORTS = 5,
    parameter int SEL_W     = 4,
    localparam int PIN_W    = NUM_PORTS * NUM_MUXED
) (
    input  logic [PIN_W-1:0]           pins_i,
    input  logic [NUM_MUXED*SEL_W-1:0] sel_i,
    output logic [NUM_MUXED-1:0]       line_o
);
    for (genvar n = 0; n < NUM_MUXED; n++) begin : g_line
        // Route the selected port's pin n onto line n.
        always_comb begin
            line_o[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel_i[n*SEL_W +: SEL_W] == SEL_W'(p)) begin
                    line_o[n] = pins_i[p*NUM_MUXED + n];
                end
            end
        end
    end
endmodule

// File: rtl/exti_edge_detect.sv
// Module exti_edge_detect: per-line edge finder that compares the current
// sample with the previous one. A reload request masks detection for one
// cycle while the previous sample takes in the newly selected source.
// Assumes cur_i is already synchronous.
module exti_edge_detect #(
    parameter int NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cur_i,
    input  logic [NUM_LINES-1:0] rise_en_i,
    input  logic [NUM_LINES-1:0] fall_en_i,
    input  logic [NUM_LINES-1:0] reload_i,
    output logic [NUM_LINES-1:0] trig_o
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] blank_q;

    // Keep the previous sample and a one-cycle blanking mark after a source change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            blank_q <= '0;
        end else begin
            prev_q  <= cur_i;
            blank_q <= reload_i;
        end
    end

    // Qualify rising and falling transitions against the enables.
    always_comb begin
        trig_o = ~blank_q & ((cur_i & ~prev_q & rise_en_i) |
                             (~cur_i & prev_q & fall_en_i));
    end

    AST_SEL_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|reload_i) |=> ((trig_o & $past(reload_i)) == '0)); // R10
endmodule

// File: rtl/exti_regs.sv
// Module exti_regs: register file for the controller. Holds the edge
// enables, both masks, the software trigger, the sticky pending flags and
// the source selectors. Assumes one write per strobe cycle and a
// combinational read.
module exti_regs
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 20,
    parameter int NUM_MUXED = 16,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    localparam int FIELDS_PER_REG = SEL_REG_BITS / SEL_W,
    localparam int NUM_SEL_REGS   = NUM_MUXED / FIELDS_PER_REG
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    input  logic [NUM_LINES-1:0]       trig_i,
    output logic [NUM_LINES-1:0]       rise_en_o,
    output logic [NUM_LINES-1:0]       fall_en_o,
    output logic [NUM_LINES-1:0]       imask_o,
    output logic [NUM_LINES-1:0]       emask_o,
    output logic [NUM_LINES-1:0]       pend_o,
    output logic [NUM_LINES-1:0]       sw_set_o,
    output logic [NUM_MUXED*SEL_W-1:0] sel_o,
    output logic [NUM_MUXED-1:0]       sel_chg_o
);
    logic [NUM_LINES-1:0] rise_q, fall_q, imask_q, emask_q, sw_q, pend_q;
    logic [NUM_LINES-1:0] sw_d, pend_d, clr, set_vec, wr_bits;
    logic [NUM_MUXED*SEL_W-1:0] sel_q, sel_d;

    assign wr_bits = wdata_i[NUM_LINES-1:0];

    // Decode software-trigger rises and pending clears from the current write.
    always_comb begin
        sw_set_o = '0;
        clr      = '0;
        if (we_i && addr_i == ADDR_W'(ADDR_SWTRIG)) sw_set_o = wr_bits & ~sw_q;
        if (we_i && addr_i == ADDR_W'(ADDR_PEND))   clr      = wr_bits;
        set_vec = trig_i | sw_set_o;
    end

    // Next pending and software-trigger state; a new trigger beats a clear.
    always_comb begin
        pend_d = (pend_q & ~clr) | set_vec;
        if (we_i && addr_i == ADDR_W'(ADDR_SWTRIG)) sw_d = wr_bits;
        else                                        sw_d = sw_q & ~clr;
    end

    // Next selector state and the per-line change flags.
    always_comb begin
        sel_d = sel_q;
        for (int k = 0; k < NUM_SEL_REGS; k++) begin
            if (we_i && addr_i == ADDR_W'(ADDR_SEL_BASE + k)) begin
                sel_d[k*SEL_REG_BITS +: SEL_REG_BITS] = wdata_i[SEL_REG_BITS-1:0];
            end
        end
        for (int n = 0; n < NUM_MUXED; n++) begin
            sel_chg_o[n] = sel_d[n*SEL_W +: SEL_W] != sel_q[n*SEL_W +: SEL_W];
        end
    end

    // Register update on the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            emask_q <= '0;
            sw_q    <= '0;
            pend_q  <= '0;
            sel_q   <= '0;
        end else begin
            if (we_i && addr_i == ADDR_W'(ADDR_RISE))  rise_q  <= wr_bits;
            if (we_i && addr_i == ADDR_W'(ADDR_FALL))  fall_q  <= wr_bits;
            if (we_i && addr_i == ADDR_W'(ADDR_IMASK)) imask_q <= wr_bits;
            if (we_i && addr_i == ADDR_W'(ADDR_EMASK)) emask_q <= wr_bits;
            sw_q   <= sw_d;
            pend_q <= pend_d;
            sel_q  <= sel_d;
        end
    end

    // Read multiplexer; unused bits and addresses return 0.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_RISE):   rdata_o[NUM_LINES-1:0] = rise_q;
            ADDR_W'(ADDR_FALL):   rdata_o[NUM_LINES-1:0] = fall_q;
            ADDR_W'(ADDR_IMASK):  rdata_o[NUM_LINES-1:0] = imask_q;
            ADDR_W'(ADDR_EMASK):  rdata_o[NUM_LINES-1:0] = emask_q;
            ADDR_W'(ADDR_SWTRIG): rdata_o[NUM_LINES-1:0] = sw_q;
            ADDR_W'(ADDR_PEND):   rdata_o[NUM_LINES-1:0] = pend_q;
            default:              rdata_o = '0;
        endcase
        for (int k = 0; k < NUM_SEL_REGS; k++) begin
            if (addr_i == ADDR_W'(ADDR_SEL_BASE + k)) begin
                rdata_o[SEL_REG_BITS-1:0] = sel_q[k*SEL_REG_BITS +: SEL_REG_BITS];
            end
        end
    end

    assign rise_en_o = rise_q;
    assign fall_en_o = fall_q;
    assign imask_o   = imask_q;
    assign emask_o   = emask_q;
    assign pend_o    = pend_q;
    assign sel_o     = sel_q;

    AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0)); // R2
    AST_SW_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_set_o) |=> ((pend_q & $past(sw_set_o)) == $past(sw_set_o))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((pend_q & $past(clr & ~set_vec)) == '0)); // R8
endmodule

// File: rtl/exti_ctrl.sv
// Module exti_ctrl: top of the external interrupt and event controller.
// It resynchronises all pins and direct inputs, selects one pin per
// multiplexed line, detects edges, keeps the pending state and drives the
// masked interrupt and event outputs. Assumes asynchronous pins and a
// register master that is synchronous to clk.
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 20,
    parameter int NUM_MUXED = 16,
    parameter int NUM_PORTS = 5,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    localparam int NUM_DIRECT = NUM_LINES - NUM_MUXED,
    localparam int PIN_W      = NUM_PORTS * NUM_MUXED,
    localparam int RAW_W      = PIN_W + NUM_DIRECT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_W-1:0]      port_pins_i,
    input  logic [NUM_DIRECT-1:0] direct_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic [NUM_LINES-1:0]  irq_o,
    output logic [NUM_LINES-1:0]  evt_o
);
    logic [RAW_W-1:0]           raw_sync;
    logic [NUM_MUXED-1:0]       mux_lines, sel_chg;
    logic [NUM_MUXED*SEL_W-1:0] sel;
    logic [NUM_LINES-1:0]       cur, reload, trig, rise_en, fall_en;
    logic [NUM_LINES-1:0]       imask, emask, pend, sw_set, evt_q;

    exti_sync #(.WIDTH(RAW_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({direct_i, port_pins_i}),
        .sync_o  (raw_sync)
    );

    exti_line_mux #(.NUM_MUXED(NUM_MUXED), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
        .pins_i (raw_sync[PIN_W-1:0]),
        .sel_i  (sel),
        .line_o (mux_lines)
    );

    assign cur    = {raw_sync[RAW_W-1:PIN_W], mux_lines};
    assign reload = {{NUM_DIRECT{1'b0}}, sel_chg};

    exti_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_i     (cur),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .reload_i  (reload),
        .trig_o    (trig)
    );

    exti_regs #(
        .NUM_LINES(NUM_LINES), .NUM_MUXED(NUM_MUXED), .SEL_W(SEL_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .trig_i    (trig),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .imask_o   (imask),
        .emask_o   (emask),
        .pend_o    (pend),
        .sw_set_o  (sw_set),
        .sel_o     (sel),
        .sel_chg_o (sel_chg)
    );

    // One-cycle event pulse for each masked trigger, independent of pending.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (trig | sw_set) & emask;
    end

    assign evt_o = evt_q;
    assign irq_o = pend & imask;

    AST_EVT_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(emask)) == '0)); // R6
endmodule

// File: tb/exti_ctrl_bench.sv
// Bench for exti_ctrl: directed corner cases followed by seeded random rounds.
module exti_ctrl_bench;
    import exti_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] pins = '0;
    logic [3:0]  direct = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [19:0] irq, evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exti_ctrl u_exti_ctrl (
        .clk(clk), .rst_n(rst_n), .port_pins_i(pins), .direct_i(direct),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .evt_o(evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 4'(a);
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected line values from pins, direct inputs and selector fields (R9, R11).
    function automatic logic [19:0] line_vals(input logic [79:0] p, input logic [3:0] d,
                                             input logic [63:0] s);
        logic [19:0] v;
        for (int n = 0; n < 16; n++) begin
            int f = int'(s[n*4 +: 4]);
            v[n] = (f < 5) ? p[f*16 + n] : 1'b0;
        end
        v[19:16] = d;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] sel;
        logic [19:0] oldv, newv, ren, fen, im, expv;
        void'($urandom(32'd2024));
        settle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 evt", 32'(evt), 0);
        for (int a = 0; a < 16; a++) begin rd(a, r); chk("R1 reg", r, 0); end

        // R2 rising edge, R5 irq, R6 masked event
        wr(ADDR_IMASK, 32'hFFFFF);
        wr(ADDR_RISE, 32'h20);
        pins[5] = 1'b1; settle(2);
        rd(ADDR_PEND, r); chk("R2 not before latency", r, 0);
        settle(1);
        rd(ADDR_PEND, r); chk("R2 rise pending", r, 32'h20);
        chk("R5 irq", 32'(irq), 32'h20);
        chk("R6 evt masked", 32'(evt), 0);
        wr(ADDR_PEND, 32'h20);
        rd(ADDR_PEND, r); chk("R8 clear", r, 0);

        // R3 falling edge, then both directions
        wr(ADDR_FALL, 32'h20);
        pins[5] = 1'b0; settle(3);
        rd(ADDR_PEND, r); chk("R3 fall pending", r, 32'h20);
        wr(ADDR_PEND, 32'h20);
        pins[5] = 1'b1; settle(3);
        rd(ADDR_PEND, r); chk("R3 both rise", r, 32'h20);
        wr(ADDR_PEND, 32'hFFFFF);

        // R4 disabled directions
        wr(ADDR_RISE, 0); wr(ADDR_FALL, 0);
        pins[5] = 1'b0; pins[6] = 1'b1; settle(4);
        pins[6] = 1'b0; settle(4);
        rd(ADDR_PEND, r); chk("R4 no trigger", r, 0);

        // R6 event pulse, one cycle, repeats while pending
        wr(ADDR_IMASK, 0);
        wr(ADDR_EMASK, 32'h80); wr(ADDR_RISE, 32'h80);
        pins[7] = 1'b1; settle(3);
        chk("R6 evt pulse", 32'(evt), 32'h80);
        chk("R5 irq masked", 32'(irq), 0);
        settle(1);
        chk("R6 evt one cycle", 32'(evt), 0);
        pins[7] = 1'b0; settle(3);
        pins[7] = 1'b1; settle(3);
        chk("R6 evt while pending", 32'(evt), 32'h80);
        wr(ADDR_PEND, 32'hFFFFF);

        // R7 software trigger
        wr(ADDR_EMASK, 32'h4);
        wr(ADDR_SWTRIG, 32'h4);
        chk("R7 sw evt", 32'(evt), 32'h4);
        rd(ADDR_PEND, r); chk("R7 sw pending", r, 32'h4);
        rd(ADDR_SWTRIG, r); chk("R7 sw stored", r, 32'h4);
        wr(ADDR_PEND, 0);
        rd(ADDR_PEND, r); chk("R8 write zero", r, 32'h4);
        wr(ADDR_PEND, 32'h4);
        rd(ADDR_SWTRIG, r); chk("R8 clears sw bit", r, 0);
        rd(ADDR_PEND, r); chk("R8 sw pending cleared", r, 0);
        wr(ADDR_SWTRIG, 32'h4);
        rd(ADDR_PEND, r); chk("R7 sw retrigger", r, 32'h4);
        wr(ADDR_PEND, 32'hFFFFF);

        // R8 trigger in the same cycle as a clear keeps pending set
        wr(ADDR_RISE, 32'h200);
        pins[9] = 1'b1; settle(2);
        we = 1'b1; addr = 4'(ADDR_PEND); wdata = 32'h200;
        @(posedge clk); @(negedge clk); we = 1'b0;
        rd(ADDR_PEND, r); chk("R8 set wins", r, 32'h200);
        wr(ADDR_PEND, 32'hFFFFF);

        // R9 selector fields and out-of-range values
        wr(ADDR_SEL_BASE, 32'h0930);
        rd(ADDR_SEL_BASE, r); chk("R12 sel readback", r, 32'h0930);
        wr(ADDR_RISE, 32'h6); wr(ADDR_FALL, 32'h4);
        pins[1] = 1'b1; settle(4);
        rd(ADDR_PEND, r); chk("R9 unselected port ignored", r, 0);
        pins[3*16+1] = 1'b1; settle(3);
        rd(ADDR_PEND, r); chk("R9 port3 line1", r, 32'h2);
        for (int p = 0; p < 5; p++) pins[p*16+2] = 1'b1;
        settle(4);
        for (int p = 0; p < 5; p++) pins[p*16+2] = 1'b0;
        settle(4);
        rd(ADDR_PEND, r); chk("R9 out-of-range held low", r, 32'h2);
        wr(ADDR_SEL_BASE + 3, 32'h0040);
        wr(ADDR_RISE, 32'h2000);
        pins[4*16+13] = 1'b1; settle(3);
        rd(ADDR_PEND, r); chk("R9 port4 line13", r, 32'h2002);
        wr(ADDR_PEND, 32'hFFFFF);

        // R10 selector change onto a high pin creates no edge
        pins[2*16+3] = 1'b1; settle(4);
        wr(ADDR_RISE, 32'h8); wr(ADDR_FALL, 32'h8); wr(ADDR_EMASK, 32'h8);
        wr(ADDR_SEL_BASE, 32'h2930);
        chk("R10 no event on switch", 32'(evt), 0);
        settle(1);
        chk("R10 no event later", 32'(evt), 0);
        settle(3);
        rd(ADDR_PEND, r); chk("R10 no pending on switch", r, 0);
        pins[2*16+3] = 1'b0; settle(3);
        rd(ADDR_PEND, r); chk("R10 new source live", r, 32'h8);
        wr(ADDR_PEND, 32'hFFFFF);

        // R11 direct line
        wr(ADDR_RISE, 32'h40000);
        direct[2] = 1'b1; settle(3);
        rd(ADDR_PEND, r); chk("R11 direct line18", r, 32'h40000);
        wr(ADDR_PEND, 32'hFFFFF);

        // R12 unused bits and addresses
        wr(ADDR_RISE, 32'hFFFFFFFF);
        rd(ADDR_RISE, r); chk("R12 upper bits", r, 32'hFFFFF);
        wr(ADDR_SEL_BASE + 1, 32'hFFFFFFFF);
        rd(ADDR_SEL_BASE + 1, r); chk("R12 sel upper bits", r, 32'hFFFF);
        rd(15, r); chk("R12 unmapped", r, 0);
        rd(6, r); chk("R12 unmapped 6", r, 0);

        // Random rounds: R2 R3 R4 R5 R9 R11 with fixed random selectors
        wr(ADDR_EMASK, 0);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] s16 = 16'($urandom);
            wr(ADDR_SEL_BASE + k, 32'(s16));
            sel[k*16 +: 16] = s16;
        end
        settle(4);
        for (int it = 0; it < 150; it++) begin
            ren = 20'($urandom); fen = 20'($urandom); im = 20'($urandom);
            wr(ADDR_RISE, 32'(ren)); wr(ADDR_FALL, 32'(fen)); wr(ADDR_IMASK, 32'(im));
            wr(ADDR_PEND, 32'hFFFFF);
            oldv = line_vals(pins, direct, sel);
            pins = pins ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
            direct = direct ^ 4'($urandom);
            newv = line_vals(pins, direct, sel);
            expv = (newv & ~oldv & ren) | (~newv & oldv & fen);
            settle(4);
            rd(ADDR_PEND, r); chk("R2/R3/R4 random pending", r, 32'(expv));
            chk("R5 random irq", 32'(irq), 32'(expv & im));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule